// File: doc/BRIEF.md
# Dual-Width Processor Bus Slave

This block is the slave end of an asynchronous parallel processor bus in a character display controller. The host drives a register-select line, a read/write line and an enable strobe, and exchanges data over a bidirectional byte-wide bus. The enable strobe is brought into the core clock domain through a synchroniser. Its synchronised edges mark the start of a transfer (rising) and the end of a transfer (falling).

A write goes either to the instruction register or to the data register, chosen by the register-select line. The block reports each completed write as a one-cycle strobe that carries the assembled byte. A read returns one of two things: the data byte supplied by downstream logic, or a status word made of the busy flag and the address counter. A completed data read raises its own strobe so that downstream logic can advance its address.

The bus runs either at full byte width or in nibble mode. In nibble mode only the upper four data lines are used and each byte takes two transfers. The bus is modelled as a data-out vector with an output enable. Instruction decoding, the memories and the display timing live outside this block.

Top module: `mpu_bus_slave`

## Requirements
- R1: With register select 0 and read/write 0, a completed write pulses `wr_ir_stb_o` with the byte on `wr_byte_o`. With register select 1 it pulses `wr_dr_stb_o` instead.
- R2: In byte mode (`nibble_mode_i`=0), the write byte is the full data bus as sampled on the synchronised falling edge of enable. A value on the bus earlier in the enable pulse has no effect.
- R3: In nibble mode (`nibble_mode_i`=1), the first transfer supplies bits 7..4 and the second supplies bits 3..0, both taken from data lines 7..4. Data lines 3..0 are ignored. A write strobe appears only after the second transfer.
- R4: The nibble position returns to "high nibble first" on reset and whenever `nibble_mode_i` changes value.
- R5: A write whose enable falls while `busy_i` is 1 is ignored. It gives no strobe and does not move the nibble position.
- R6: A read with register select 0 returns `busy_i` on bit 7 and `addr_cnt_i` on bits 6..0.
- R7: A read with register select 1 returns `rd_data_i`. A completed data read pulses `rd_dr_stb_o`, and a status read does not.
- R8: A nibble-mode read returns the upper half of the selected word on lines 7..4, then its lower half on lines 7..4, with lines 3..0 driven 0. Both halves come from the word captured at the first transfer, and `rd_dr_stb_o` pulses only after the second.
- R9: `bus_d_oe_o` is 1 only during a read, from one cycle after the synchronised rising edge of enable to one cycle after its falling edge. It is 0 after reset and during writes.
- R10: `wr_ir_stb_o`, `wr_dr_stb_o` and `rd_dr_stb_o` are each one cycle wide, never active together, and 0 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| nibble_mode_i | input | 1 | 1 selects the 4-bit transfer mode |
| bus_rs_i | input | 1 | Register select: 0 instruction/status, 1 data |
| bus_rw_i | input | 1 | 0 write, 1 read |
| bus_en_i | input | 1 | Asynchronous transfer enable strobe |
| bus_d_i | input | DW | Data bus as seen at the pins |
| bus_d_o | output | DW | Data driven onto the bus during reads |
| bus_d_oe_o | output | 1 | Bus driver enable; 0 means high impedance |
| busy_i | input | 1 | Busy flag from the controller core |
| addr_cnt_i | input | DW-1 | Current address counter |
| rd_data_i | input | DW | Data byte offered for a data read |
| wr_ir_stb_o | output | 1 | Instruction register write strobe |
| wr_dr_stb_o | output | 1 | Data register write strobe |
| wr_byte_o | output | DW | Byte written, valid with either write strobe |
| rd_dr_stb_o | output | 1 | Data read completed strobe |

## Verification
The assertions assume that register select and read/write are stable from before enable rises until the synchronised falling edge has been seen. They also assume that enable stays high and low for longer than the synchroniser delay, so that two edges never fall in adjacent cycles. The write data is likewise assumed to be held past the synchronised falling edge. The stimulus sets up select, direction and data two cycles before raising enable, keeps enable in each level for six cycles, and holds all lines for six cycles after enable drops. It changes the width mode only between transfers.

// File: rtl/mpu_bus_pkg.sv
package mpu_bus_pkg;

  // Which half of a byte the next nibble-mode transfer carries.
  typedef enum logic {
    PH_HI = 1'b0,
    PH_LO = 1'b1
  } nib_phase_e;

endpackage

// File: rtl/mpu_bus_sync.sv
module mpu_bus_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic level_o,
  output logic rise_o,
  output logic fall_o
);

  logic [STAGES-1:0] stg_q;
  logic [STAGES-1:0] stg_d;
  logic              dly_q;

  generate
    if (STAGES == 1) begin : g_one
      assign stg_d = async_i;
    end else begin : g_many
      assign stg_d = {stg_q[STAGES-2:0], async_i};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg_q <= '0;
      dly_q <= 1'b0;
    end else begin
      stg_q <= stg_d;
      dly_q <= stg_q[STAGES-1];
    end
  end

  assign level_o = stg_q[STAGES-1];
  assign rise_o  = stg_q[STAGES-1] & ~dly_q;
  assign fall_o  = ~stg_q[STAGES-1] & dly_q;

endmodule

// File: rtl/mpu_bus_phase.sv
module mpu_bus_phase
  import mpu_bus_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       nibble_mode_i,
  input  logic       adv_i,
  output nib_phase_e phase_o
);

  logic       mode_q;
  nib_phase_e phase_q;
  nib_phase_e phase_d;

  always_comb begin
    phase_d = phase_q;
    if (nibble_mode_i != mode_q) begin
      phase_d = PH_HI;
    end else if (adv_i && nibble_mode_i) begin
      phase_d = (phase_q == PH_HI) ? PH_LO : PH_HI;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= 1'b0;
      phase_q <= PH_HI;
    end else begin
      mode_q  <= nibble_mode_i;
      phase_q <= phase_d;
    end
  end

  assign phase_o = phase_q;

endmodule

// File: rtl/mpu_bus_rd_path.sv
module mpu_bus_rd_path #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic          stop_i,
  input  logic          nibble_i,
  input  logic          lo_i,
  input  logic [DW-1:0] src_i,
  output logic [DW-1:0] bus_d_o,
  output logic          oe_o
);

  localparam int NW = DW / 2;

  logic [DW-1:0] hold_q, hold_d;
  logic [DW-1:0] dout_q, dout_d;
  logic          oe_q, oe_d;

  always_comb begin
    hold_d = hold_q;
    dout_d = dout_q;
    oe_d   = oe_q;
    if (stop_i) begin
      oe_d = 1'b0;
    end
    if (start_i) begin
      oe_d = 1'b1;
      if (nibble_i && lo_i) begin
        dout_d = {hold_q[NW-1:0], {NW{1'b0}}};
      end else begin
        hold_d = src_i;
        dout_d = nibble_i ? {src_i[DW-1 -: NW], {NW{1'b0}}} : src_i;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= '0;
      dout_q <= '0;
      oe_q   <= 1'b0;
    end else begin
      hold_q <= hold_d;
      dout_q <= dout_d;
      oe_q   <= oe_d;
    end
  end

  assign bus_d_o = dout_q;
  assign oe_o    = oe_q;

endmodule

// File: rtl/mpu_bus_slave.sv
module mpu_bus_slave
  import mpu_bus_pkg::*;
#(
  parameter int DW          = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          nibble_mode_i,
  input  logic          bus_rs_i,
  input  logic          bus_rw_i,
  input  logic          bus_en_i,
  input  logic [DW-1:0] bus_d_i,
  output logic [DW-1:0] bus_d_o,
  output logic          bus_d_oe_o,
  input  logic          busy_i,
  input  logic [DW-2:0] addr_cnt_i,
  input  logic [DW-1:0] rd_data_i,
  output logic          wr_ir_stb_o,
  output logic          wr_dr_stb_o,
  output logic [DW-1:0] wr_byte_o,
  output logic          rd_dr_stb_o
);

  localparam int NW = DW / 2;

  logic       en_level, en_rise, en_fall;
  logic       rs_q, rw_q;
  nib_phase_e phase;
  logic       lo_phase;
  logic       xfer_last;
  logic       wr_take;
  logic       phase_adv;

  logic [NW-1:0] hi_q;
  logic [DW-1:0] byte_next;
  logic [DW-1:0] byte_q;
  logic          ir_stb_d, dr_stb_d, rd_stb_d;
  logic          ir_stb_q, dr_stb_q, rd_stb_q;
  logic [DW-1:0] rd_src;

  mpu_bus_sync #(.STAGES(SYNC_STAGES)) i_en_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i (bus_en_i),
    .level_o (en_level),
    .rise_o  (en_rise),
    .fall_o  (en_fall)
  );

  // Select and direction are held for the whole transfer once enable rises.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_q <= 1'b0;
      rw_q <= 1'b0;
    end else if (en_rise) begin
      rs_q <= bus_rs_i;
      rw_q <= bus_rw_i;
    end
  end

  assign lo_phase  = (phase == PH_LO);
  assign xfer_last = ~nibble_mode_i | lo_phase;
  assign wr_take   = en_fall & ~rw_q & ~busy_i;
  assign phase_adv = en_fall & (rw_q | ~busy_i);

  mpu_bus_phase i_phase (
    .clk           (clk),
    .rst_n         (rst_n),
    .nibble_mode_i (nibble_mode_i),
    .adv_i         (phase_adv),
    .phase_o       (phase)
  );

  // Write assembly
  assign byte_next = nibble_mode_i ? {hi_q, bus_d_i[DW-1 -: NW]} : bus_d_i;

  always_comb begin
    ir_stb_d = wr_take & xfer_last & ~rs_q;
    dr_stb_d = wr_take & xfer_last &  rs_q;
    rd_stb_d = en_fall & rw_q & rs_q & xfer_last;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q <= '0;
    end else if (wr_take && nibble_mode_i && !lo_phase) begin
      hi_q <= bus_d_i[DW-1 -: NW];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      byte_q <= '0;
    end else if (wr_take && xfer_last) begin
      byte_q <= byte_next;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ir_stb_q <= 1'b0;
      dr_stb_q <= 1'b0;
      rd_stb_q <= 1'b0;
    end else begin
      ir_stb_q <= ir_stb_d;
      dr_stb_q <= dr_stb_d;
      rd_stb_q <= rd_stb_d;
    end
  end

  // Read source: status word or data byte
  assign rd_src = bus_rs_i ? rd_data_i : {busy_i, addr_cnt_i};

  mpu_bus_rd_path #(.DW(DW)) i_rd_path (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (en_rise & bus_rw_i),
    .stop_i   (en_fall),
    .nibble_i (nibble_mode_i),
    .lo_i     (lo_phase),
    .src_i    (rd_src),
    .bus_d_o  (bus_d_o),
    .oe_o     (bus_d_oe_o)
  );

  assign wr_ir_stb_o = ir_stb_q;
  assign wr_dr_stb_o = dr_stb_q;
  assign wr_byte_o   = byte_q;
  assign rd_dr_stb_o = rd_stb_q;

  logic unused_level;
  assign unused_level = en_level;

endmodule

// File: rtl/mpu_bus_slave_chk.sv
module mpu_bus_slave_chk (
  input logic clk,
  input logic rst_n,
  input logic bus_rw_i,
  input logic nibble_mode_i,
  input logic busy_i,
  input logic bus_d_oe_o,
  input logic wr_ir_stb_o,
  input logic wr_dr_stb_o,
  input logic rd_dr_stb_o,
  input logic en_fall,
  input logic lo_phase
);

  AST_DRIVE_ONLY_READ: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_d_oe_o) |-> $past(bus_rw_i)); // R9

  AST_RELEASE_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    en_fall |=> !bus_d_oe_o); // R9

  AST_STROBE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({wr_ir_stb_o, wr_dr_stb_o, rd_dr_stb_o})); // R10

  AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ir_stb_o || wr_dr_stb_o || rd_dr_stb_o) |=>
      !(wr_ir_stb_o || wr_dr_stb_o || rd_dr_stb_o)); // R10

  AST_BUSY_BLOCKS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (en_fall && busy_i) |=> !(wr_ir_stb_o || wr_dr_stb_o)); // R5

  AST_MODE_SWITCH_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (nibble_mode_i != $past(nibble_mode_i)) |=> !lo_phase); // R4

  AST_BYTE_MODE_NO_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
    !nibble_mode_i |=> !lo_phase); // R2

endmodule

bind mpu_bus_slave mpu_bus_slave_chk i_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .bus_rw_i      (bus_rw_i),
  .nibble_mode_i (nibble_mode_i),
  .busy_i        (busy_i),
  .bus_d_oe_o    (bus_d_oe_o),
  .wr_ir_stb_o   (wr_ir_stb_o),
  .wr_dr_stb_o   (wr_dr_stb_o),
  .rd_dr_stb_o   (rd_dr_stb_o),
  .en_fall       (en_fall),
  .lo_phase      (lo_phase)
);

// File: tb/test_mpu_bus_slave.sv
`timescale 1ns/1ps
module test_mpu_bus_slave;

  localparam int DW   = 8;
  localparam int SYNC = 2;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          nibble_mode;
  logic          bus_rs, bus_rw, bus_en;
  logic [DW-1:0] bus_d;
  logic [DW-1:0] bus_d_o;
  logic          bus_d_oe;
  logic          busy;
  logic [DW-2:0] addr_cnt;
  logic [DW-1:0] rd_data;
  logic          wr_ir_stb, wr_dr_stb, rd_dr_stb;
  logic [DW-1:0] wr_byte;

  always #2.5 clk = ~clk;

  mpu_bus_slave #(.DW(DW), .SYNC_STAGES(SYNC)) i_mpu_bus_slave (
    .clk           (clk),
    .rst_n         (rst_n),
    .nibble_mode_i (nibble_mode),
    .bus_rs_i      (bus_rs),
    .bus_rw_i      (bus_rw),
    .bus_en_i      (bus_en),
    .bus_d_i       (bus_d),
    .bus_d_o       (bus_d_o),
    .bus_d_oe_o    (bus_d_oe),
    .busy_i        (busy),
    .addr_cnt_i    (addr_cnt),
    .rd_data_i     (rd_data),
    .wr_ir_stb_o   (wr_ir_stb),
    .wr_dr_stb_o   (wr_dr_stb),
    .wr_byte_o     (wr_byte),
    .rd_dr_stb_o   (rd_dr_stb)
  );

  int    n_cmp = 0;
  int    n_bad = 0;
  string req   = "R9";
  bit    done  = 1'b0;

  int       c_ir = 0, c_dr = 0, c_rd = 0;
  logic [7:0] last_byte = 8'h00;

  // Behavioural reference state
  logic [SYNC-1:0] m_sync = '0;
  logic m_d = 0, m_rs = 0, m_rw = 0, m_lo = 0, m_mode = 0, m_oe = 0;
  logic m_ir = 0, m_dr = 0, m_rd = 0;
  logic [3:0] m_hi = 4'h0;
  logic [7:0] m_hold = 8'h00, m_dout = 8'h00, m_byte = 8'h00;

  task automatic chk(input string r, input string what, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", r, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    logic s, rise, fall, last, lo_n, n_ir, n_dr, n_rd;
    logic [7:0] v;
    if (!done) begin
      chk(req, "bus enable", bus_d_oe, m_oe);
      chk(req, "ir strobe", wr_ir_stb, m_ir);
      chk(req, "dr strobe", wr_dr_stb, m_dr);
      chk(req, "read strobe", rd_dr_stb, m_rd);
      if (m_oe) chk(req, "bus data", bus_d_o, m_dout);
      if (m_ir || m_dr) chk(req, "write byte", wr_byte, m_byte);
      if (wr_ir_stb) begin c_ir++; last_byte = wr_byte; end
      if (wr_dr_stb) begin c_dr++; last_byte = wr_byte; end
      if (rd_dr_stb) c_rd++;

      if (!rst_n) begin
        m_sync = '0; m_d = 0; m_rs = 0; m_rw = 0; m_lo = 0; m_mode = 0; m_oe = 0;
        m_ir = 0; m_dr = 0; m_rd = 0; m_hi = 0; m_hold = 0; m_dout = 0; m_byte = 0;
      end else begin
        s    = m_sync[SYNC-1];
        rise = s & ~m_d;
        fall = ~s & m_d;
        n_ir = 0; n_dr = 0; n_rd = 0;
        lo_n = m_lo;
        if (rise) begin
          m_rs = bus_rs;
          m_rw = bus_rw;
          if (bus_rw) begin
            m_oe = 1;
            if (nibble_mode && m_lo) m_dout = {m_hold[3:0], 4'h0};
            else begin
              v = bus_rs ? rd_data : {busy, addr_cnt};
              m_hold = v;
              m_dout = nibble_mode ? {v[7:4], 4'h0} : v;
            end
          end
        end
        if (fall) begin
          m_oe = 0;
          last = !nibble_mode || m_lo;
          if (!m_rw && !busy) begin
            if (last) begin
              m_byte = nibble_mode ? {m_hi, bus_d[7:4]} : bus_d;
              n_ir = !m_rs;
              n_dr = m_rs;
            end else m_hi = bus_d[7:4];
          end
          if (m_rw && m_rs && last) n_rd = 1;
          if (nibble_mode && (m_rw || !busy)) lo_n = !m_lo;
        end
        if (nibble_mode != m_mode) lo_n = 0;
        m_lo = lo_n;
        m_mode = nibble_mode;
        m_ir = n_ir; m_dr = n_dr; m_rd = n_rd;
        m_sync = {m_sync[SYNC-2:0], bus_en};
        m_d = s;
      end
    end
  end

  task automatic tick(input int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic xfer(input logic rs, input logic rw, input logic [7:0] d);
    bus_rs = rs; bus_rw = rw; bus_d = d;
    tick(2);
    bus_en = 1'b1;
    tick(5);
    @(negedge clk);
    if (!rw) chk("R9", "bus driven during write", bus_d_oe, 0);
    @(posedge clk); #1;
    bus_en = 1'b0;
    tick(6);
  endtask

  // Write whose data only settles late in the enable pulse.
  task automatic xfer_late(input logic rs, input logic [7:0] early, input logic [7:0] d);
    bus_rs = rs; bus_rw = 1'b0; bus_d = early;
    tick(2);
    bus_en = 1'b1;
    tick(4);
    bus_d = d;
    tick(2);
    bus_en = 1'b0;
    tick(6);
  endtask

  task automatic rd_expect(input logic rs, input logic [7:0] exp, input string r);
    bus_rs = rs; bus_rw = 1'b1; bus_d = 8'h00;
    tick(2);
    bus_en = 1'b1;
    tick(5);
    @(negedge clk);
    chk(r, "bus driven during read", bus_d_oe, 1);
    chk(r, "read value", bus_d_o, exp);
    @(posedge clk); #1;
    bus_en = 1'b0;
    tick(6);
    chk(r, "bus released after read", bus_d_oe, 0);
  endtask

  initial begin
    rst_n = 1'b0; nibble_mode = 1'b0; bus_rs = 1'b0; bus_rw = 1'b0; bus_en = 1'b0;
    bus_d = 8'h00; busy = 1'b0; addr_cnt = 7'h00; rd_data = 8'h00;
    tick(4);
    rst_n = 1'b1;
    tick(3);

    req = "R9";
    chk("R9", "bus enable after reset", bus_d_oe, 0);
    chk("R10", "strobes after reset", {wr_ir_stb, wr_dr_stb, rd_dr_stb}, 0);

    req = "R1";
    xfer(1'b0, 1'b0, 8'h38);
    chk("R1", "ir write count", c_ir, 1);
    chk("R1", "ir byte", last_byte, 8'h38);
    chk("R1", "dr write count", c_dr, 0);

    req = "R2";
    xfer_late(1'b1, 8'h00, 8'h5A);
    chk("R2", "dr write count", c_dr, 1);
    chk("R2", "byte sampled at falling edge", last_byte, 8'h5A);

    req = "R6";
    busy = 1'b1; addr_cnt = 7'h45;
    rd_expect(1'b0, 8'hC5, "R6");
    busy = 1'b0; addr_cnt = 7'h12;
    rd_expect(1'b0, 8'h12, "R6");
    chk("R7", "no read strobe on status", c_rd, 0);

    req = "R7";
    rd_data = 8'h3C;
    rd_expect(1'b1, 8'h3C, "R7");
    chk("R7", "read strobe count", c_rd, 1);

    req = "R5";
    busy = 1'b1;
    xfer(1'b1, 1'b0, 8'hFF);
    busy = 1'b0;
    chk("R5", "busy write ignored", c_dr, 1);

    req = "R3";
    nibble_mode = 1'b1;
    tick(2);
    xfer(1'b0, 1'b0, 8'h2A);
    chk("R3", "no strobe after high nibble", c_ir, 1);
    xfer(1'b0, 1'b0, 8'h85);
    chk("R3", "strobe after low nibble", c_ir, 2);
    chk("R3", "nibble byte", last_byte, 8'h28);

    req = "R5";
    busy = 1'b1;
    xfer(1'b1, 1'b0, 8'hF0);
    busy = 1'b0;
    xfer(1'b1, 1'b0, 8'h6F);
    chk("R5", "busy nibble did not advance", c_dr, 1);
    xfer(1'b1, 1'b0, 8'h1C);
    chk("R5", "byte after busy nibble", last_byte, 8'h61);
    chk("R5", "dr write count", c_dr, 2);

    req = "R4";
    xfer(1'b1, 1'b0, 8'h70);
    nibble_mode = 1'b0;
    tick(3);
    nibble_mode = 1'b1;
    tick(3);
    xfer(1'b1, 1'b0, 8'h90);
    chk("R4", "mode change restarts at high nibble", c_dr, 2);
    xfer(1'b1, 1'b0, 8'h60);
    chk("R4", "dr write count", c_dr, 3);
    chk("R4", "byte after mode change", last_byte, 8'h96);

    req = "R8";
    rd_data = 8'hB4;
    rd_expect(1'b1, 8'hB0, "R8");
    chk("R8", "no read strobe after high nibble", c_rd, 1);
    rd_data = 8'h00;
    rd_expect(1'b1, 8'h40, "R8");
    chk("R8", "read strobe after low nibble", c_rd, 2);

    req = "R10";
    nibble_mode = 1'b0;
    tick(3);
    xfer(1'b0, 1'b0, 8'h01);
    rd_data = 8'h77;
    rd_expect(1'b1, 8'h77, "R10");
    xfer(1'b1, 1'b0, 8'hE3);
    chk("R10", "ir count", c_ir, 3);
    chk("R10", "dr count", c_dr, 4);
    chk("R10", "read count", c_rd, 3);
    chk("R10", "last byte", last_byte, 8'hE3);

    tick(2);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_bad++;
      $display("FAIL R10 watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule